// File: doc/BRIEF.md
# Parallel Flash Bus and Command Controller

This block sits on the host side of a small NOR-style flash array. It turns the active-low select, output-enable and write-enable strobes into read and write cycles. Writes are gathered into unlock-style command sequences by a state machine, and reads return array words, identifier codes or busy status. A width input selects the data path. When it is 1 the path is a 16-bit word bus. When it is 0 the path is a byte bus: the top data input line becomes the address bit below `addr[0]` and the middle lines are left undriven. The array is an internal memory of `2**ADDR_W` words. A program or erase is committed only after a busy period of `BUSY_CYC` cycles, and a reset during that period cancels it.

The state machine has the following states:

- `S_READ` is the idle read-array state.
- `S_UNLK1` and `S_UNLK2` follow the two unlock writes.
- `S_PROG` waits for the program data of a four-cycle program.
- `S_AUTO` returns identifier codes.
- `S_ERS0`, `S_ERS1` and `S_ERS2` form the erase setup and its second unlock pair.
- `S_BYPASS` is the shortened-program mode.
- `S_BPROG` waits for the program data of a bypass program.
- `S_BUSY` runs the program or erase and returns status.

The transitions are as follows:

- `S_READ` goes to `S_UNLK1` on the first unlock write. `S_UNLK1` goes to `S_UNLK2` on the second unlock write.
- From `S_UNLK2`, the command byte selects one of four states: 0xA0 goes to `S_PROG`, 0x20 to `S_BYPASS`, 0x90 to `S_AUTO` and 0x80 to `S_ERS0`.
- `S_ERS0` goes to `S_ERS1` and then to `S_ERS2` on a repeat of the unlock pair. In `S_ERS2`, the byte 0x10 goes to `S_BUSY`.
- `S_PROG` and `S_BPROG` go to `S_BUSY` on the data write.
- `S_BYPASS` goes to `S_BPROG` on 0xA0.
- `S_BUSY` ends in `S_READ`, or in `S_BYPASS` when the program started there.
- Any other write returns the machine to `S_READ`.

With the default `ADDR_W` of 8, the unlock addresses 0x555 and 0x2AA truncate to 0x55 and 0xAA.

Top module: `flash_bus_ctrl`

## Requirements
- R1: After reset the block is in read-array mode. With `wide_sel`=1, a read (`cs_n`=0, `oe_n`=0, `we_n`=1) drives all 16 `dq_oe` bits high and `dq_out` equals the array word at `addr`.
- R2: With `wide_sel`=0, a read drives `dq_oe`=0x00FF. `dq_out[7:0]` is the high byte of the word when `dq_in[15]`=1 and the low byte when it is 0. A byte program writes only the selected byte.
- R3: `dq_oe` is 0 whenever `cs_n`=1, `oe_n`=1 or `we_n`=0.
- R4: Writing 0xAA at 0x55, 0x55 at 0xAA and 0xA0 at 0x55, followed by a data write, programs the word at the data address with the AND of the old word and the data.
- R5: Writing 0xAA at 0x55, 0x55 at 0xAA and 0x20 at 0x55 enters bypass mode. In that mode each program needs only 0xA0 at any address plus the data write, and the block returns to bypass mode when the program completes. Any other write in bypass mode returns to read-array.
- R6: After 0xAA at 0x55, 0x55 at 0xAA and 0x90 at 0x55, a read returns `MFR_ID` for `addr[1:0]`=0, `DEV_ID` for 1 and 0x00 otherwise, all on bits 7..0, with bits 15..8 driven as 0.
- R7: Writing 0xAA at 0x55, 0x55 at 0xAA, 0x80 at 0x55, 0xAA at 0x55, 0x55 at 0xAA and 0x10 at 0x55 sets every word to 0xFFFF once the busy period ends.
- R8: For `BUSY_CYC` cycles after the last write of a program or erase, reads return a status byte. Bit 7 is the complement of bit 7 of the programmed byte, or 0 for an erase. Bit 6 inverts on each read cycle. All other bits are 0. Writes during this period are ignored.
- R9: Writing 0xF0 at any address returns to read-array from any state except `S_BUSY`, `S_PROG` and `S_BPROG`; in the last two, the write is taken as program data. A write that does not match the expected sequence also returns to read-array.
- R10: While `rst_n`=0 every `dq_oe` bit is 0. A program or erase in progress is dropped without changing the array, and read-array mode follows.
- R11: If `addr` last changed before clock edge E (counted as edge 0), `sleep` is 0 before edge E+`SLEEP_CYC` and 1 from that edge on. Read data stays valid while `sleep` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; a write takes effect on its falling edge |
| wide_sel | input | 1 | 1 selects the 16-bit bus, 0 selects the byte bus |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data; in byte mode, bit 15 is the byte-select address bit |
| dq_out | output | 16 | Read data |
| dq_oe | output | 16 | Per-line output enable |
| sleep | output | 1 | Address-stable sleep indication |

## Verification
The bench builds the block with `ADDR_W`=8, `BUSY_CYC`=12 and `SLEEP_CYC`=10. With these values it can read all 256 words after an erase and after a bypass program of the whole array, and read all 512 bytes in byte mode. A busy period of 12 cycles leaves room for two status reads and two ignored writes inside it. The short sleep limit lets the bench check the exact edge at which `sleep` rises.

// File: rtl/flash_pkg.sv
package flash_pkg;
    typedef enum logic [3:0] {
        S_READ, S_UNLK1, S_UNLK2, S_PROG, S_AUTO,
        S_ERS0, S_ERS1, S_ERS2, S_BYPASS, S_BPROG, S_BUSY
    } cmd_state_t;

    localparam logic [7:0] CMD_KEY1   = 8'hAA;
    localparam logic [7:0] CMD_KEY2   = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_BYPASS = 8'h20;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_EXIT   = 8'hF0;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BUSY_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_stb,
    output cmd_state_t        state,
    output logic              op_erase,
    output logic              toggle,
    output logic              prog_go,
    output logic              commit_prog,
    output logic              commit_erase
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(12'h555);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(12'h2AA);

    cmd_state_t       state_nx;
    logic [CNT_W-1:0] cnt;
    logic             ret_bypass;
    logic             start_erase;
    logic             last_cyc;

    assign last_cyc = (state == S_BUSY) && (cnt == CNT_W'(BUSY_CYC - 1));

    always_comb begin
        state_nx    = state;
        start_erase = 1'b0;
        unique case (state)
            S_BUSY:   if (last_cyc) state_nx = ret_bypass ? S_BYPASS : S_READ;
            S_PROG,
            S_BPROG:  if (wr_stb) state_nx = S_BUSY;
            S_READ:   if (wr_stb) state_nx = (wr_addr == A_HI && wr_data == CMD_KEY1) ? S_UNLK1 : S_READ;
            S_UNLK1:  if (wr_stb) state_nx = (wr_addr == A_LO && wr_data == CMD_KEY2) ? S_UNLK2 : S_READ;
            S_UNLK2:  if (wr_stb) begin
                state_nx = S_READ;
                if (wr_addr == A_HI) begin
                    unique case (wr_data)
                        CMD_PROG:   state_nx = S_PROG;
                        CMD_BYPASS: state_nx = S_BYPASS;
                        CMD_IDENT:  state_nx = S_AUTO;
                        CMD_ERASE:  state_nx = S_ERS0;
                        default:    state_nx = S_READ;
                    endcase
                end
            end
            S_AUTO:   if (wr_stb) state_nx = S_READ;
            S_ERS0:   if (wr_stb) state_nx = (wr_addr == A_HI && wr_data == CMD_KEY1) ? S_ERS1 : S_READ;
            S_ERS1:   if (wr_stb) state_nx = (wr_addr == A_LO && wr_data == CMD_KEY2) ? S_ERS2 : S_READ;
            S_ERS2:   if (wr_stb) begin
                if (wr_addr == A_HI && wr_data == CMD_CHIP) begin
                    state_nx    = S_BUSY;
                    start_erase = 1'b1;
                end else begin
                    state_nx = S_READ;
                end
            end
            S_BYPASS: if (wr_stb) state_nx = (wr_data == CMD_PROG) ? S_BPROG : S_READ;
            default:  state_nx = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_READ;
            cnt        <= '0;
            ret_bypass <= 1'b0;
            op_erase   <= 1'b0;
            toggle     <= 1'b0;
        end else begin
            state <= state_nx;
            if (prog_go || start_erase) begin
                cnt        <= '0;
                ret_bypass <= (state == S_BPROG);
                op_erase   <= start_erase;
            end else if (state == S_BUSY && !last_cyc) begin
                cnt <= cnt + 1'b1;
            end
            if (state == S_BUSY && rd_stb) toggle <= ~toggle;
        end
    end

    always_comb begin
        prog_go      = wr_stb && (state == S_PROG || state == S_BPROG);
        commit_prog  = last_cyc && !op_erase;
        commit_erase = last_cyc && op_erase;
    end

    // R9
    f0_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_data == CMD_EXIT && state != S_BUSY && state != S_PROG && state != S_BPROG)
        |=> state == S_READ);
    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY) |-> (cnt < CNT_W'(BUSY_CYC)));
    // R8
    status_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && rd_stb) |=> (toggle != $past(toggle)));
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && !last_cyc) |=> (state == S_BUSY));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              byte_wr,
    input  logic              byte_hi,
    input  logic              prog_go,
    input  logic              commit_prog,
    input  logic              commit_erase,
    output logic [15:0]       rdata,
    output logic              pend_b7
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [15:0]       mem [DEPTH];
    logic [ADDR_W-1:0] pend_addr;
    logic [15:0]       pend_mask;

    always_ff @(posedge clk) begin
        if (prog_go) begin
            pend_addr <= addr;
            pend_b7   <= wdata[7];
            if (!byte_wr)    pend_mask <= wdata;
            else if (byte_hi) pend_mask <= {wdata[7:0], 8'hFF};
            else              pend_mask <= {8'hFF, wdata[7:0]};
        end
        if (commit_prog) begin
            mem[pend_addr] <= mem[pend_addr] & pend_mask;
        end else if (commit_erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/flash_sleep_timer.sv
module flash_sleep_timer #(
    parameter int ADDR_W    = 8,
    parameter int SLEEP_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              sleep
);
    localparam int SCNT_W = $clog2(SLEEP_CYC + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [SCNT_W-1:0] scnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            scnt   <= '0;
            sleep  <= 1'b0;
        end else begin
            addr_q <= addr;
            if (addr != addr_q) begin
                scnt  <= '0;
                sleep <= 1'b0;
            end else if (scnt == SCNT_W'(SLEEP_CYC - 1)) begin
                sleep <= 1'b1;
            end else begin
                scnt <= scnt + 1'b1;
            end
        end
    end

    // R11
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != $past(addr)) |=> !sleep);
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
    import flash_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         BUSY_CYC  = 16,
    parameter int         SLEEP_CYC = 32,
    parameter logic [7:0] MFR_ID    = 8'h37,
    parameter logic [7:0] DEV_ID    = 8'hB4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wide_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic              sleep
);
    cmd_state_t  state;
    logic        we_q, rd_q, wr_stb, rd_now, rd_stb, rd_en;
    logic        op_erase, toggle, prog_go, commit_prog, commit_erase;
    logic        byte_hi, pend_b7;
    logic [15:0] arr_rdata, lane, oe_mask;
    logic [7:0]  id_byte, status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            rd_q <= 1'b0;
        end else begin
            we_q <= we_n;
            rd_q <= rd_now;
        end
    end

    assign byte_hi = !wide_sel && dq_in[15];
    assign wr_stb  = rst_n && we_q && !we_n && !cs_n && oe_n;
    assign rd_now  = !cs_n && !oe_n && we_n;
    assign rd_stb  = rd_now && !rd_q;

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(addr),
        .wr_data(dq_in[7:0]), .rd_stb(rd_stb), .state(state),
        .op_erase(op_erase), .toggle(toggle), .prog_go(prog_go),
        .commit_prog(commit_prog), .commit_erase(commit_erase)
    );

    flash_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .addr(addr), .wdata(dq_in), .byte_wr(!wide_sel),
        .byte_hi(byte_hi), .prog_go(prog_go), .commit_prog(commit_prog),
        .commit_erase(commit_erase), .rdata(arr_rdata), .pend_b7(pend_b7)
    );

    flash_sleep_timer #(.ADDR_W(ADDR_W), .SLEEP_CYC(SLEEP_CYC)) u_sleep (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sleep(sleep)
    );

    always_comb begin
        unique case (addr[1:0])
            2'd0:    id_byte = MFR_ID;
            2'd1:    id_byte = DEV_ID;
            default: id_byte = 8'h00;
        endcase
        status = {op_erase ? 1'b0 : ~pend_b7, toggle, 6'b0};
        unique case (state)
            S_AUTO:  lane = {8'h00, id_byte};
            S_BUSY:  lane = {8'h00, status};
            default: lane = arr_rdata;
        endcase
        rd_en = rst_n && rd_now;
        if (wide_sel) begin
            dq_out  = lane;
            oe_mask = 16'hFFFF;
        end else begin
            dq_out  = {8'h00, (byte_hi && state != S_AUTO && state != S_BUSY) ? lane[15:8] : lane[7:0]};
            oe_mask = 16'h00FF;
        end
        dq_oe = rd_en ? oe_mask : 16'h0000;
    end

    // R3
    out_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oe_n || !we_n) |-> (dq_oe == 16'h0000));
    // R2
    byte_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_sel) |-> (dq_oe[15:8] == 8'h00));
    // R6
    ident_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AUTO && wide_sel && dq_oe[0]) |-> (dq_out[15:8] == 8'h00));
endmodule

// File: tb/flash_bus_ctrl_bench.sv
module flash_bus_ctrl_bench;
    localparam int         ADDR_W    = 8;
    localparam int         BUSY_CYC  = 12;
    localparam int         SLEEP_CYC = 10;
    localparam int         DEPTH     = 1 << ADDR_W;
    localparam logic [7:0] MFR       = 8'h37;
    localparam logic [7:0] DEV       = 8'hB4;

    logic clk = 1'b0;
    logic rst_n, cs_n, oe_n, we_n, wide_sel, sleep;
    logic [ADDR_W-1:0] addr;
    logic [15:0] dq_in, dq_out, dq_oe;
    int checks = 0;
    int errors = 0;
    logic [15:0] exp_mem [DEPTH];
    logic [15:0] rd_val, rd_oe, s1, s2;

    always #4 clk = ~clk;

    flash_bus_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC), .SLEEP_CYC(SLEEP_CYC),
                     .MFR_ID(MFR), .DEV_ID(DEV)) u_flash_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .wide_sel(wide_sel), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .sleep(sleep)
    );

    function automatic logic [15:0] pat(int a);
        return 16'(a * 257) ^ 16'h5A3C;
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d, input logic hi = 1'b0);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        addr = ADDR_W'(a); dq_in = {hi, 7'b0, d};
        @(posedge clk);
        @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic wr16(input int a, input logic [15:0] d);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        addr = ADDR_W'(a); dq_in = d;
        @(posedge clk);
        @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic rd(input int a, input logic hi = 1'b0);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        addr = ADDR_W'(a); dq_in = {hi, 15'b0};
        #1;
        rd_val = dq_out; rd_oe = dq_oe;
        @(posedge clk);
        @(negedge clk);
        oe_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        wide_sel = 1'b1; addr = '0; dq_in = '0;
        repeat (2) @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0;
        #1;
        chk(dq_oe, 16'h0000, "R10 outputs off in reset");
        chk({15'b0, sleep}, 16'h0000, "R11 sleep low in reset");
        @(negedge clk);
        rst_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);

        rd(0);
        chk(rd_oe, 16'hFFFF, "R1 word read drives all lines");

        // R7 chip erase
        unlock(); wr(12'h555, 8'h80); unlock(); wr(12'h555, 8'h10);
        rd(0); s1 = rd_val;
        rd(0); s2 = rd_val;
        chk({8'h00, s1[7], 7'b0}, 16'h0000, "R8 erase status bit7");
        chk({15'b0, s1[6] ^ s2[6]}, 16'h0001, "R8 status bit6 toggles");
        repeat (BUSY_CYC) @(posedge clk);
        for (int a = 0; a < DEPTH; a++) begin
            rd(a);
            chk(rd_val, 16'hFFFF, "R7 erased word");
        end

        // R5 bypass program of whole array
        unlock(); wr(12'h555, 8'h20);
        for (int a = 0; a < DEPTH; a++) begin
            wr(a ^ 8'h3C, 8'hA0);
            wr16(a, pat(a));
            repeat (BUSY_CYC) @(posedge clk);
            exp_mem[a] = pat(a);
        end
        wr(0, 8'hF0);
        for (int a = 0; a < DEPTH; a++) begin
            rd(a);
            chk(rd_val, exp_mem[a], "R5 R1 bypass-programmed word");
        end

        // R4 standard program with AND, R8 status and ignored writes
        unlock(); wr(12'h555, 8'hA0); wr16(3, 16'h0F70);
        rd(3); s1 = rd_val;
        rd(3); s2 = rd_val;
        chk(s1 & 16'hFFBF, 16'h0080, "R8 program status bit7 inverted, rest zero");
        chk({15'b0, s1[6] ^ s2[6]}, 16'h0001, "R8 status bit6 toggles");
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
        repeat (BUSY_CYC) @(posedge clk);
        exp_mem[3] = exp_mem[3] & 16'h0F70;
        wr(12'h555, 8'hA0); wr16(9, 16'h0000);
        repeat (BUSY_CYC) @(posedge clk);
        rd(3);
        chk(rd_val, exp_mem[3], "R4 programmed word is AND");
        rd(9);
        chk(rd_val, exp_mem[9], "R8 writes during busy ignored");

        // R2 byte mode sweep and byte program
        wide_sel = 1'b0;
        for (int b = 0; b < 2 * DEPTH; b++) begin
            rd(b >> 1, 1'(b & 1));
            chk({rd_oe[15:8], rd_val[7:0]},
                {8'h00, (b & 1) != 0 ? exp_mem[b >> 1][15:8] : exp_mem[b >> 1][7:0]},
                "R2 byte read");
            chk(rd_oe[7:0] == 8'hFF ? 16'h1 : 16'h0, 16'h1, "R2 low lines driven");
        end
        unlock(); wr(12'h555, 8'hA0); wr(5, 8'h0F, 1'b1);
        repeat (BUSY_CYC) @(posedge clk);
        exp_mem[5] = exp_mem[5] & 16'h0FFF;
        wide_sel = 1'b1;
        rd(5);
        chk(rd_val, exp_mem[5], "R2 byte program touches one byte");

        // R6 autoselect
        unlock(); wr(12'h555, 8'h90);
        rd(0); chk(rd_val, {8'h00, MFR}, "R6 maker code");
        rd(1); chk(rd_val, {8'h00, DEV}, "R6 device code");
        rd(2); chk(rd_val, 16'h0000, "R6 other code");
        rd(2); chk(rd_oe, 16'hFFFF, "R6 driven word");
        wr(8'h20, 8'hF0);
        rd(0); chk(rd_val, exp_mem[0], "R9 F0 returns to array");
        wr(12'h555, 8'hAA); wr(8'h10, 8'h55); wr(12'h555, 8'h90);
        rd(0); chk(rd_val, exp_mem[0], "R9 bad sequence back to array");

        // R3 output disable
        @(negedge clk); addr = 8'h11; cs_n = 1'b0; oe_n = 1'b1; #1;
        chk(dq_oe, 16'h0000, "R3 oe high");
        cs_n = 1'b1; oe_n = 1'b0; #1;
        chk(dq_oe, 16'h0000, "R3 deselected");
        cs_n = 1'b0; we_n = 1'b0; #1;
        chk(dq_oe, 16'h0000, "R3 we low");
        @(negedge clk); cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(posedge clk);

        // R10 reset aborts a program
        unlock(); wr(12'h555, 8'hA0); wr16(7, 16'h0000);
        @(negedge clk); rst_n = 1'b0; cs_n = 1'b0; oe_n = 1'b0; #1;
        chk(dq_oe, 16'h0000, "R10 outputs off during reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1;
        rd(7); chk(rd_val, exp_mem[7], "R10 read-array right after reset");
        repeat (BUSY_CYC) @(posedge clk);
        rd(7); chk(rd_val, exp_mem[7], "R10 aborted program left word");

        // R11 sleep
        @(negedge clk); addr = 8'h33;
        repeat (SLEEP_CYC) @(posedge clk);
        @(negedge clk);
        chk({15'b0, sleep}, 16'h0000, "R11 sleep low before limit");
        @(posedge clk);
        @(negedge clk);
        chk({15'b0, sleep}, 16'h0001, "R11 sleep high at limit");
        cs_n = 1'b0; oe_n = 1'b0; #1;
        chk(dq_out, exp_mem[8'h33], "R11 data valid in sleep");
        @(negedge clk); cs_n = 1'b1; oe_n = 1'b1; addr = 8'h34;
        @(posedge clk);
        @(negedge clk);
        chk({15'b0, sleep}, 16'h0000, "R11 address change clears sleep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule